// File: doc/BRIEF.md
# Vector Lane Broadcast and Permute Unit

This block rearranges pieces of 256-bit vectors in one registered stage. It can broadcast a 32-, 64- or 128-bit scalar into every element of the result. It can write a 128-bit value into one half of a vector, or read one half back out. It can rebuild a vector from any halves of two source vectors, with an optional forced zero for each half. It can also reorder 32-bit or 64-bit elements inside each 128-bit lane, with a selector taken from a second vector for each element. A vector execution pipe issues one operation per cycle by raising the valid strobe with an opcode, the operands and an 8-bit control byte. The result comes back one clock later.

The unit has no memory access. All operands arrive on ports, and the result stays registered until the next valid operation replaces it.

Top module: `vlane_xbar`

## Requirements
- R1: While reset (`rst_n` low) is held, `res_vld` is 0 and `res_data` is all zeros.
- R2: `res_vld` is 1 in the cycle after a cycle with `in_vld` high, and 0 in the cycle after a cycle with `in_vld` low.
- R3: The broadcast opcodes copy the scalar into every element of the result. Opcode 0 copies `src_h[31:0]` into all eight 32-bit elements, opcode 1 copies `src_h[63:0]` into all four 64-bit elements, and opcode 2 copies `src_h` into both 128-bit halves.
- R4: Insert (opcode 3) returns `src_a` with one half replaced by `src_h`: the low half when `imm[0]` is 0, the high half when `imm[0]` is 1. The other half is unchanged.
- R5: Extract (opcode 4) places `src_a[127:0]` (when `imm[0]` is 0) or `src_a[255:128]` (when `imm[0]` is 1) in `res_data[127:0]`, and drives `res_data[255:128]` to zero.
- R6: In two-source permute (opcode 5), `imm[1:0]` selects the source of result bits 127:0 and `imm[5:4]` selects the source of bits 255:128. Code 0 is `src_a[127:0]`, 1 is `src_a[255:128]`, 2 is `src_b[127:0]` and 3 is `src_b[255:128]`.
- R7: In permute, `imm[3]` set forces result bits 127:0 to zero and `imm[7]` set forces bits 255:128 to zero, whatever the selection code.
- R8: In the 32-bit shuffle (opcode 6), result element e (bits 32e+31:32e) takes the element of `src_a` in the same 128-bit lane indexed by `src_b[32e+1:32e]`. The other selector bits are ignored.
- R9: In the 64-bit shuffle (opcode 7), result element e (bits 64e+63:64e) takes the 64-bit element of `src_a` in the same lane indexed by `src_b[64e+1]`. Every other selector bit is ignored.
- R10: A cycle with `in_vld` low leaves `res_data` unchanged, whatever values the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation issue strobe |
| op | input | 3 | Operation code (0..7, see requirements) |
| src_a | input | 256 | First vector operand |
| src_b | input | 256 | Second vector operand, or shuffle selectors |
| src_h | input | 128 | Scalar or half-vector operand |
| imm | input | 8 | Control byte |
| res_vld | output | 1 | Result valid, one cycle after `in_vld` |
| res_data | output | 256 | Registered result |

## Verification
Two functions can act on the same result half in the same cycle. The permute selection code picks a source half, and the zero bit for that half forces it to zero. The bench provokes this by issuing permutes in which a half's zero bit is set together with a selection code that points at nonzero data, once for each half and once for both halves. It judges the result by whether the forced half reads zero while the other half still carries its selected source. A second overlap occurs when a new operation is issued in the same cycle as the previous result is presented. Back-to-back issues confirm that each result replaces the last with no gap, and idle cycles with junk on the operands confirm that the last result is held.

// File: rtl/vlx_pkg.sv
package vlx_pkg;
   typedef enum logic [2:0] {
      VLX_BC_S   = 3'd0,
      VLX_BC_D   = 3'd1,
      VLX_BC_Q   = 3'd2,
      VLX_INS    = 3'd3,
      VLX_EXT    = 3'd4,
      VLX_PERM   = 3'd5,
      VLX_SHUF_S = 3'd6,
      VLX_SHUF_D = 3'd7
   } vlx_op_e;
endpackage

// File: rtl/vlx_bcast.sv
module vlx_bcast #(
   parameter int LANE_W = 128,
   parameter int ES     = 32,
   parameter int ED     = 64
) (
   input  logic [LANE_W-1:0]   scal,
   output logic [2*LANE_W-1:0] bc_s,
   output logic [2*LANE_W-1:0] bc_d,
   output logic [2*LANE_W-1:0] bc_q
);
   localparam int VEC_W = 2 * LANE_W;
   localparam int NS    = VEC_W / ES;
   localparam int ND    = VEC_W / ED;

   for (genvar k = 0; k < NS; k++) begin : g_s
      assign bc_s[k*ES +: ES] = scal[ES-1:0];
   end
   for (genvar k = 0; k < ND; k++) begin : g_d
      assign bc_d[k*ED +: ED] = scal[ED-1:0];
   end
   for (genvar k = 0; k < 2; k++) begin : g_q
      assign bc_q[k*LANE_W +: LANE_W] = scal;
   end
endmodule

// File: rtl/vlx_half.sv
module vlx_half #(
   parameter int LANE_W = 128,
   parameter int IMM_W  = 8
) (
   input  logic [2*LANE_W-1:0] va,
   input  logic [2*LANE_W-1:0] vb,
   input  logic [LANE_W-1:0]   hv,
   input  logic [IMM_W-1:0]    ctl,
   output logic [2*LANE_W-1:0] ins_o,
   output logic [2*LANE_W-1:0] ext_o,
   output logic [2*LANE_W-1:0] perm_o
);
   logic [LANE_W-1:0] quad [4];
   logic [LANE_W-1:0] p_lo, p_hi;

   assign quad[0] = va[LANE_W-1:0];
   assign quad[1] = va[2*LANE_W-1:LANE_W];
   assign quad[2] = vb[LANE_W-1:0];
   assign quad[3] = vb[2*LANE_W-1:LANE_W];

   // Half select for insert and extract is ctl[0].
   assign ins_o = ctl[0] ? {hv, quad[0]} : {quad[1], hv};
   assign ext_o = {{LANE_W{1'b0}}, (ctl[0] ? quad[1] : quad[0])};

   // Per-half selection with a zero override for each half.
   always_comb begin
      p_lo = ctl[3] ? '0 : quad[ctl[1:0]];
      p_hi = ctl[7] ? '0 : quad[ctl[5:4]];
   end
   assign perm_o = {p_hi, p_lo};
endmodule

// File: rtl/vlx_shuf.sv
module vlx_shuf #(
   parameter int LANE_W  = 128,
   parameter int ELEM    = 32,
   parameter int SEL_LSB = 0
) (
   input  logic [2*LANE_W-1:0] data,
   input  logic [2*LANE_W-1:0] sel,
   output logic [2*LANE_W-1:0] shuf_o
);
   localparam int VEC_W = 2 * LANE_W;
   localparam int NE    = VEC_W / ELEM;
   localparam int PER   = LANE_W / ELEM;
   localparam int SW    = $clog2(PER);

   for (genvar e = 0; e < NE; e++) begin : g_el
      localparam int LBASE = (e / PER) * LANE_W;
      logic [SW-1:0]     idx;
      logic [LANE_W-1:0] lane;
      assign idx  = sel[e*ELEM+SEL_LSB +: SW];
      assign lane = data[LBASE +: LANE_W];
      assign shuf_o[e*ELEM +: ELEM] = lane[idx*ELEM +: ELEM];
   end
endmodule

// File: rtl/vlane_xbar.sv
module vlane_xbar
   import vlx_pkg::*;
#(
   parameter int LANE_W   = 128,
   parameter int ES       = 32,
   parameter int ED       = 64,
   parameter int IMM_W    = 8,
   parameter int SELD_LSB = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic [2:0]          op,
   input  logic [2*LANE_W-1:0] src_a,
   input  logic [2*LANE_W-1:0] src_b,
   input  logic [LANE_W-1:0]   src_h,
   input  logic [IMM_W-1:0]    imm,
   output logic                res_vld,
   output logic [2*LANE_W-1:0] res_data
);
   localparam int VEC_W = 2 * LANE_W;

   if (ED != 2 * ES) begin : g_chk_ed
      $error("vlane_xbar: ED must be twice ES");
   end
   if (LANE_W % ED != 0 || LANE_W / ED < 2) begin : g_chk_lane
      $error("vlane_xbar: LANE_W must hold at least two ED elements");
   end
   if (IMM_W < 8) begin : g_chk_imm
      $error("vlane_xbar: IMM_W must be at least 8");
   end
   if (SELD_LSB + $clog2(LANE_W / ED) > ED) begin : g_chk_sel
      $error("vlane_xbar: SELD_LSB out of element range");
   end

   logic [VEC_W-1:0] bc_s, bc_d, bc_q;
   logic [VEC_W-1:0] ins_v, ext_v, perm_v;
   logic [VEC_W-1:0] sh_s, sh_d;
   logic [VEC_W-1:0] nxt;
   vlx_op_e          opc;

   assign opc = vlx_op_e'(op);

   vlx_bcast #(.LANE_W(LANE_W), .ES(ES), .ED(ED)) u_bc (
      .scal(src_h), .bc_s(bc_s), .bc_d(bc_d), .bc_q(bc_q)
   );

   vlx_half #(.LANE_W(LANE_W), .IMM_W(IMM_W)) u_half (
      .va(src_a), .vb(src_b), .hv(src_h), .ctl(imm),
      .ins_o(ins_v), .ext_o(ext_v), .perm_o(perm_v)
   );

   vlx_shuf #(.LANE_W(LANE_W), .ELEM(ES), .SEL_LSB(0)) u_shs (
      .data(src_a), .sel(src_b), .shuf_o(sh_s)
   );

   vlx_shuf #(.LANE_W(LANE_W), .ELEM(ED), .SEL_LSB(SELD_LSB)) u_shd (
      .data(src_a), .sel(src_b), .shuf_o(sh_d)
   );

   always_comb begin
      unique case (opc)
         VLX_BC_S:   nxt = bc_s;
         VLX_BC_D:   nxt = bc_d;
         VLX_BC_Q:   nxt = bc_q;
         VLX_INS:    nxt = ins_v;
         VLX_EXT:    nxt = ext_v;
         VLX_PERM:   nxt = perm_v;
         VLX_SHUF_S: nxt = sh_s;
         VLX_SHUF_D: nxt = sh_d;
         default:    nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld  <= 1'b0;
         res_data <= '0;
      end else begin
         res_vld <= in_vld;
         if (in_vld) res_data <= nxt;
      end
   end
endmodule

// File: rtl/vlane_xbar_chk.sv
module vlane_xbar_chk #(
   parameter int LANE_W = 128,
   parameter int IMM_W  = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_vld,
   input logic [2:0]          op,
   input logic [IMM_W-1:0]    imm,
   input logic                res_vld,
   input logic [2*LANE_W-1:0] res_data
);
   AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> res_vld);                                                  // R2
   AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !res_vld);                                                // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(res_data));                                       // R10
   AST_EXT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && op == 3'd4) |=> (res_data[2*LANE_W-1:LANE_W] == '0));      // R5
   AST_PERM_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && op == 3'd5 && imm[3]) |=> (res_data[LANE_W-1:0] == '0));   // R7
   AST_PERM_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && op == 3'd5 && imm[7]) |=> (res_data[2*LANE_W-1:LANE_W] == '0)); // R7
   AST_BCQ_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && op == 3'd2) |=>
         (res_data[2*LANE_W-1:LANE_W] == res_data[LANE_W-1:0]));            // R3
endmodule

bind vlane_xbar vlane_xbar_chk #(.LANE_W(LANE_W), .IMM_W(IMM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .imm(imm),
   .res_vld(res_vld), .res_data(res_data)
);

// File: tb/vlane_xbar_tb.sv
module vlane_xbar_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_vld = 1'b0;
   logic [2:0]   op = '0;
   logic [255:0] src_a = '0, src_b = '0;
   logic [127:0] src_h = '0;
   logic [7:0]   imm = '0;
   logic         res_vld;
   logic [255:0] res_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   bit           q_vld [$];
   logic [255:0] q_dat [$];
   string        q_req [$];
   logic [255:0] last_exp = '0;

   always #2.5 clk = ~clk;

   vlane_xbar u_dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op),
      .src_a(src_a), .src_b(src_b), .src_h(src_h), .imm(imm),
      .res_vld(res_vld), .res_data(res_data)
   );

   function automatic logic [255:0] mk(input logic [31:0] seed);
      logic [255:0] r;
      for (int k = 0; k < 8; k++) r[32*k +: 32] = seed ^ (32'h1357_0000 + 32'h0101_0011 * k);
      return r;
   endfunction

   function automatic logic [255:0] model(input logic [2:0] o, input logic [255:0] a,
                                          input logic [255:0] b, input logic [127:0] h,
                                          input logic [7:0] c);
      logic [255:0] r;
      logic [127:0] hv [4];
      int s;
      hv[0] = a[127:0]; hv[1] = a[255:128]; hv[2] = b[127:0]; hv[3] = b[255:128];
      r = '0;
      case (o)
         3'd0: for (int k = 0; k < 8; k++) r[32*k +: 32] = h[31:0];
         3'd1: for (int k = 0; k < 4; k++) r[64*k +: 64] = h[63:0];
         3'd2: r = {h, h};
         3'd3: r = c[0] ? {h, a[127:0]} : {a[255:128], h};
         3'd4: r = {128'd0, c[0] ? a[255:128] : a[127:0]};
         3'd5: begin
            r[127:0]   = c[3] ? 128'd0 : hv[c[1:0]];
            r[255:128] = c[7] ? 128'd0 : hv[c[5:4]];
         end
         3'd6: for (int e = 0; e < 8; e++) begin
            s = int'(b[32*e +: 2]);
            r[32*e +: 32] = a[(e/4)*128 + 32*s +: 32];
         end
         default: for (int e = 0; e < 4; e++) begin
            s = int'(b[64*e + 1]);
            r[64*e +: 64] = a[(e/2)*128 + 64*s +: 64];
         end
      endcase
      return r;
   endfunction

   task automatic issue(input logic [2:0] o, input logic [255:0] a, input logic [255:0] b,
                        input logic [127:0] h, input logic [7:0] c, input string req);
      @(negedge clk);
      in_vld = 1'b1; op = o; src_a = a; src_b = b; src_h = h; imm = c;
      last_exp = model(o, a, b, h, c);
      q_vld.push_back(1'b1); q_dat.push_back(last_exp); q_req.push_back(req);
   endtask

   task automatic idle(input logic [31:0] junk);
      @(negedge clk);
      in_vld = 1'b0; op = junk[2:0]; src_a = mk(junk); src_b = mk(~junk);
      src_h = mk(junk ^ 32'h5a5a)[127:0]; imm = junk[15:8];
      q_vld.push_back(1'b0); q_dat.push_back(last_exp); q_req.push_back("R2/R10");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // Monitor: one expected item per cycle, compared just after the capturing edge.
   initial begin
      bit           ev;
      logic [255:0] ed;
      string        er;
      forever begin
         @(posedge clk);
         #1;
         if (q_vld.size() > 0) begin
            ev = q_vld.pop_front(); ed = q_dat.pop_front(); er = q_req.pop_front();
            checks++;
            if (res_vld !== ev || res_data !== ed) begin
               errors++;
               $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
                        er, res_vld, res_data, ev, ed);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      logic [255:0] A, B, S;
      A = mk(32'hA0A0_0001);
      B = mk(32'hB0B0_0002);
      repeat (3) @(negedge clk);
      checks++;
      if (res_vld !== 1'b0 || res_data !== '0) begin
         errors++;
         $display("FAIL R1: vld=%0b data=%h expected vld=0 data=0", res_vld, res_data);
      end
      rst_n = 1'b1;
      idle(32'h0);
      // R3 broadcasts
      issue(3'd0, A, B, 128'hFFFF_EEEE_DDDD_CCCC_BBBB_AAAA_1234_5678, 8'h00, "R3 bc32");
      issue(3'd1, A, B, 128'h1111_2222_3333_4444_89AB_CDEF_0246_8ACE, 8'hFF, "R3 bc64");
      issue(3'd2, A, B, 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555, 8'h00, "R3 bc128");
      // R4 insert both halves
      issue(3'd3, A, B, 128'hCAFE_F00D_CAFE_F00D_CAFE_F00D_CAFE_F00D, 8'h00, "R4 ins lo");
      issue(3'd3, A, B, 128'hCAFE_F00D_CAFE_F00D_CAFE_F00D_CAFE_F00D, 8'h01, "R4 ins hi");
      // R5 extract
      issue(3'd4, A, B, '0, 8'h00, "R5 ext lo");
      issue(3'd4, A, B, '0, 8'hFE ^ 8'h01, "R5 ext hi");
      // R6 selection codes
      issue(3'd5, A, B, '0, 8'h10, "R6 perm 1/0");
      issue(3'd5, A, B, '0, 8'h32, "R6 perm 3/2");
      issue(3'd5, A, B, '0, 8'h23, "R6 perm 2/3");
      issue(3'd5, A, B, '0, 8'h01, "R6 perm 0/1");
      // R7 zero override colliding with selection
      issue(3'd5, A, B, '0, 8'h3B, "R7 zero lo");
      issue(3'd5, A, B, '0, 8'hA1, "R7 zero hi");
      issue(3'd5, A, B, '0, 8'hBB, "R7 zero both");
      idle(32'h7777_1234);
      idle(32'h0F0F_8888);
      // R8 32-bit shuffle, junk in upper selector bits
      S = '0;
      for (int e = 0; e < 8; e++) S[32*e +: 32] = 32'hFFFF_FFF0 | ((e * 3 + 1) % 4);
      issue(3'd6, A, S, '0, 8'h00, "R8 shuf32");
      for (int e = 0; e < 8; e++) S[32*e +: 32] = 32'h0000_0000 | (3 - (e % 4));
      issue(3'd6, B, S, '0, 8'h00, "R8 shuf32 rev");
      // R9 64-bit shuffle, bit 0 and high bits as junk
      S = '0;
      for (int e = 0; e < 4; e++) S[64*e +: 64] = (e % 2 == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h1;
      issue(3'd7, A, S, '0, 8'h00, "R9 shuf64");
      for (int e = 0; e < 4; e++) S[64*e +: 64] = (e < 2) ? 64'h2 : 64'hFFFF_FFFF_FFFF_FFFD;
      issue(3'd7, B, S, '0, 8'h00, "R9 shuf64 b");
      // R10 hold with junk on operands
      idle(32'h1234_5678);
      idle(32'hFFFF_FFFF);
      idle(32'h0000_0005);
      issue(3'd2, B, A, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 8'h00, "R3 bc128 b2b");
      idle(32'h0);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule